// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Bit-Clock Output

A 16-bit timer/counter peripheral with one 8-bit control register. The count advances on an internal tick enable or on falling edges of an external event pin. A 16-bit capture/reload register does two jobs. In capture mode, a falling edge on an external strobe pin copies the live count into it. In reload mode, its contents are loaded back into the counter on overflow and, if enabled, on a strobe edge.

The block raises an overflow flag and an external-event flag, and drives an interrupt request from them. It can also hand its overflow pulses to a serial port as a receive or transmit bit clock. Selecting either bit-clock use forces reload mode, suppresses the overflow flag and blocks the strobe. Software reaches the control register, the two count bytes and the two capture/reload bytes over a small register bus. Writes take effect at the clock edge and reads are combinational.

Top module: `cr_timer16`

## Requirements
- R1: After reset the control register, count and capture/reload register read 0x00, and irq, rx_clk and tx_clk are low. The bus map is: address 0 is control, 1 and 2 are the count low and high bytes, and 3 and 4 are the capture/reload low and high bytes. Control bits, from 7 down to 0: ovf, ext, rx_sel, tx_sel, strobe_en, run, evt_sel, cap_sel.
- R2: The count does not advance while run is 0.
- R3: With evt_sel at 0, the count rises by one on each cycle with tick_en high. With evt_sel at 1, tick_en is ignored and the count rises by one on each falling edge of evt_pin, including a carry from the low byte into the high byte.
- R4: An overflow (count 0xFFFF stepping) sets ovf. The flag stays set until software writes 0 to bit 7. In capture mode the count wraps to 0x0000.
- R5: With cap_sel=1 and strobe_en=1, a falling edge of strb_pin copies the count into the capture/reload register.
- R6: With cap_sel=0, an overflow loads the count from the capture/reload register. With strobe_en=1, a strobe falling edge also loads it.
- R7: When rx_sel or tx_sel is 1, overflow always reloads whatever cap_sel is, ovf is not set, and strobe edges cause no capture, no reload and no flag.
- R8: A strobe edge that captures or reloads sets ext, which stays set until software clears it. With strobe_en=0, strobe edges change nothing.
- R9: irq is high exactly when ovf or ext is set.
- R10: Each overflow gives a one-cycle pulse on tx_clk when tx_sel=1 and on rx_clk when rx_sel=1, in the cycle after the overflow edge.
- R11: A software write to a count byte in the same cycle as an overflow reload wins for that byte. The other byte takes the reload value.
- R12: A hardware flag set in the same cycle as a software write that clears it leaves the flag set.
- R13: Pin inputs pass a two-flop synchronizer. A pin falling edge takes effect at the third rising clock edge after the pin changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | Internal count tick enable |
| evt_pin | input | 1 | External event input (asynchronous) |
| strb_pin | input | 1 | External capture/reload strobe (asynchronous) |
| reg_addr | input | 3 | Register bus address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt request |
| rx_clk | output | 1 | Overflow pulse for serial receive clock |
| tx_clk | output | 1 | Overflow pulse for serial transmit clock |

## Verification
Bus writes and tick-driven counts show up on the read port in the half-cycle after the edge that takes them. The bench drives inputs on falling clock edges and reads on the next falling edge. Strobe and event effects appear three rising edges after the pin moves, so the bench waits four full cycles before checking them. The bit-clock pulses last exactly the cycle after the overflow edge. The bench samples them at that falling edge and again one cycle later to confirm they have dropped. For the same-cycle cases, the software write and the tick are driven in one cycle, and the result is read on the following falling edge.

// File: rtl/cr_timer_pkg.sv
package cr_timer_pkg;

   // control register layout, bit 7 first
   typedef struct packed {
      logic ovf;
      logic ext;
      logic rx_sel;
      logic tx_sel;
      logic strb_en;
      logic run;
      logic evt_sel;
      logic cap_sel;
   } ctrl_t;

   localparam int unsigned BYTE_W    = 8;
   localparam int unsigned ADDR_CTRL = 0;

   function automatic int unsigned cnt_addr(input int unsigned b);
      return 1 + b;
   endfunction

   function automatic int unsigned cap_addr(input int unsigned b, input int unsigned nbytes);
      return 1 + nbytes + b;
   endfunction

endpackage

// File: rtl/cr_edge_sync.sv
module cr_edge_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic fall
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cr_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], pin};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign fall = prev_q & ~chain_q[STAGES-1];

endmodule

// File: rtl/cr_ctrl_reg.sv
module cr_ctrl_reg
   import cr_timer_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [7:0] wdata,
   input  logic       set_ovf,
   input  logic       set_ext,
   output ctrl_t      ctrl_q
);

   ctrl_t wr_val;
   assign wr_val = ctrl_t'(wdata);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (wr_en) begin
            ctrl_q <= wr_val;
         end
         // hardware set beats a same-cycle software clear
         if (set_ovf) ctrl_q.ovf <= 1'b1;
         if (set_ext) ctrl_q.ext <= 1'b1;
      end
   end

endmodule

// File: rtl/cr_count_core.sv
module cr_count_core #(
   parameter int unsigned CNT_W = 16,
   localparam int unsigned NB   = CNT_W / 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             reload,
   input  logic             capture,
   input  logic [NB-1:0]    cnt_wr,
   input  logic [NB-1:0]    cap_wr,
   input  logic [7:0]       wdata,
   output logic [CNT_W-1:0] cnt_q,
   output logic [CNT_W-1:0] cap_q,
   output logic             at_max
);

   logic [CNT_W-1:0] cnt_step;
   assign cnt_step = cnt_q + CNT_W'(1);
   assign at_max   = &cnt_q;

   genvar b;
   generate
      for (b = 0; b < NB; b++) begin : g_byte
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q[b*8 +: 8] <= '0;
            end else if (cnt_wr[b]) begin
               cnt_q[b*8 +: 8] <= wdata;
            end else if (reload) begin
               cnt_q[b*8 +: 8] <= cap_q[b*8 +: 8];
            end else if (inc) begin
               cnt_q[b*8 +: 8] <= cnt_step[b*8 +: 8];
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cap_q[b*8 +: 8] <= '0;
            end else if (cap_wr[b]) begin
               cap_q[b*8 +: 8] <= wdata;
            end else if (capture) begin
               cap_q[b*8 +: 8] <= cnt_q[b*8 +: 8];
            end
         end
      end
   endgenerate

endmodule

// File: rtl/cr_baud_out.sv
module cr_baud_out (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_ev,
   input  logic rx_sel,
   input  logic tx_sel,
   output logic rx_pulse,
   output logic tx_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_pulse <= 1'b0;
         tx_pulse <= 1'b0;
      end else begin
         rx_pulse <= ovf_ev & rx_sel;
         tx_pulse <= ovf_ev & tx_sel;
      end
   end

endmodule

// File: rtl/cr_timer16.sv
module cr_timer16
   import cr_timer_pkg::*;
#(
   parameter int unsigned CNT_W       = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_en,
   input  logic              evt_pin,
   input  logic              strb_pin,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   output logic              irq,
   output logic              rx_clk,
   output logic              tx_clk
);

   localparam int unsigned NB = CNT_W / 8;

   generate
      if ((CNT_W % 8) != 0 || CNT_W < 8) begin : g_bad_width
         $error("cr_timer16: CNT_W must be a nonzero multiple of 8");
      end
      if ((2 * NB + 1) > (1 << ADDR_W)) begin : g_bad_addr
         $error("cr_timer16: ADDR_W too small for register map");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cap_q;
   logic             at_max;
   logic             evt_fall;
   logic             strb_fall;
   logic [NB-1:0]    cnt_wr;
   logic [NB-1:0]    cap_wr;
   logic             ctrl_wr;

   cr_edge_sync #(.STAGES(SYNC_STAGES)) u_evt_sync (
      .clk(clk), .rst_n(rst_n), .pin(evt_pin), .fall(evt_fall)
   );

   cr_edge_sync #(.STAGES(SYNC_STAGES)) u_strb_sync (
      .clk(clk), .rst_n(rst_n), .pin(strb_pin), .fall(strb_fall)
   );

   // bus decode
   assign ctrl_wr = reg_wr && (reg_addr == ADDR_W'(ADDR_CTRL));

   genvar b;
   generate
      for (b = 0; b < NB; b++) begin : g_dec
         assign cnt_wr[b] = reg_wr && (reg_addr == ADDR_W'(cnt_addr(b)));
         assign cap_wr[b] = reg_wr && (reg_addr == ADDR_W'(cap_addr(b, NB)));
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      if (reg_addr == ADDR_W'(ADDR_CTRL)) reg_rdata = ctrl_q;
      for (int i = 0; i < NB; i++) begin
         if (reg_addr == ADDR_W'(cnt_addr(i)))     reg_rdata = cnt_q[i*8 +: 8];
         if (reg_addr == ADDR_W'(cap_addr(i, NB))) reg_rdata = cap_q[i*8 +: 8];
      end
   end

   // mode resolution
   logic baud_use;
   logic reload_mode;
   logic strb_act;
   logic inc;
   logic ovf_ev;
   logic reload;
   logic capture;

   assign baud_use    = ctrl_q.rx_sel | ctrl_q.tx_sel;
   assign reload_mode = baud_use | ~ctrl_q.cap_sel;
   assign strb_act    = ctrl_q.strb_en & ~baud_use & strb_fall;
   assign inc         = ctrl_q.run & (ctrl_q.evt_sel ? evt_fall : tick_en);
   assign ovf_ev      = inc & at_max;
   assign reload      = (ovf_ev & reload_mode) | (strb_act & ~ctrl_q.cap_sel);
   assign capture     = strb_act & ctrl_q.cap_sel;

   cr_count_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .inc(inc), .reload(reload), .capture(capture),
      .cnt_wr(cnt_wr), .cap_wr(cap_wr), .wdata(reg_wdata),
      .cnt_q(cnt_q), .cap_q(cap_q), .at_max(at_max)
   );

   cr_ctrl_reg u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata),
      .set_ovf(ovf_ev & ~baud_use), .set_ext(strb_act), .ctrl_q(ctrl_q)
   );

   cr_baud_out u_baud (
      .clk(clk), .rst_n(rst_n), .ovf_ev(ovf_ev),
      .rx_sel(ctrl_q.rx_sel), .tx_sel(ctrl_q.tx_sel),
      .rx_pulse(rx_clk), .tx_pulse(tx_clk)
   );

   assign irq = ctrl_q.ovf | ctrl_q.ext;

endmodule

// File: rtl/cr_timer16_chk.sv
module cr_timer16_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned ADDR_W = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [7:0]        ctrl,
   input logic [CNT_W-1:0]  cnt,
   input logic [CNT_W-1:0]  cap,
   input logic              rx_clk,
   input logic              tx_clk
);

   // R2
   run_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl[2]) && !$past(reg_wr) && !$past(ctrl[3])) |-> $stable(cnt));

   // R8
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!$past(ctrl[3]) && !$past(reg_wr)) |-> $stable(cap));

   // R7
   no_ovf_in_baud_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl[7]) && !$past(reg_wr)) |-> !$past(ctrl[5] | ctrl[4]));

   // R8
   ext_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ctrl[6]) && !$past(reg_wr)) |-> ($past(ctrl[3]) && !$past(ctrl[5] | ctrl[4])));

   // R10
   tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tx_clk |-> $past(ctrl[4]));

   // R10
   rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_clk |-> $past(ctrl[5]));

endmodule

bind cr_timer16 cr_timer16_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .ctrl(ctrl_q), .cnt(cnt_q), .cap(cap_q), .rx_clk(rx_clk), .tx_clk(tx_clk)
);

// File: tb/sim_cr_timer16.sv
`timescale 1ns/1ps
module sim_cr_timer16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       evt_pin = 1'b0;
   logic       strb_pin = 1'b1;
   logic [2:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic       irq, rx_clk, tx_clk;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   cr_timer16 u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .evt_pin(evt_pin),
      .strb_pin(strb_pin), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
      .rx_clk(rx_clk), .tx_clk(tx_clk)
   );

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_wr = 1'b0; reg_addr = a; #1;
      d = reg_rdata;
   endtask

   task automatic rd16(input logic [2:0] base, output logic [15:0] v);
      logic [7:0] lo, hi;
      rd(base, lo); rd(base + 3'd1, hi);
      v = {hi, lo};
   endtask

   task automatic set16(input logic [2:0] base, input logic [15:0] v);
      wr(base, v[7:0]); wr(base + 3'd1, v[15:8]);
   endtask

   task automatic ticks(input int n);
      @(negedge clk); tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
   endtask

   task automatic settle();
      repeat (4) @(negedge clk);
   endtask

   // {read(1)/write(0), addr[2:0], data[7:0]}
   localparam int NV = 14;
   localparam logic [11:0] VEC [NV] = '{
      {1'b0, 3'd1, 8'h34}, {1'b0, 3'd2, 8'h12}, {1'b1, 3'd1, 8'h34}, {1'b1, 3'd2, 8'h12},
      {1'b0, 3'd3, 8'hCD}, {1'b0, 3'd4, 8'hAB}, {1'b1, 3'd3, 8'hCD}, {1'b1, 3'd4, 8'hAB},
      {1'b0, 3'd0, 8'h08}, {1'b1, 3'd0, 8'h08}, {1'b0, 3'd0, 8'hC0}, {1'b1, 3'd0, 8'hC0},
      {1'b0, 3'd0, 8'h00}, {1'b1, 3'd0, 8'h00}
   };

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin : main
      logic [7:0]  b;
      logic [15:0] v;

      repeat (3) @(negedge clk);
      // R1 reset state
      rd(3'd0, b); chk("R1 ctrl", b, 8'h00);
      rd16(3'd1, v); chk("R1 count", v, 16'h0000);
      rd16(3'd3, v); chk("R1 cap", v, 16'h0000);
      chk("R1 outs", {irq, rx_clk, tx_clk}, 3'b000);
      rst_n = 1'b1;
      settle();

      // R1 register map via vector table
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][11]) begin
            @(negedge clk);
            rd(VEC[i][10:8], b); chk("R1 map", b, VEC[i][7:0]);
         end else begin
            wr(VEC[i][10:8], VEC[i][7:0]);
            if (VEC[i][10:8] == 3'd0 && VEC[i][7:0] == 8'hC0) begin
               chk("R9 irq from flags", irq, 1'b1);
            end
         end
      end
      chk("R9 irq low", irq, 1'b0);

      // R2 run=0 holds count
      set16(3'd1, 16'h0100);
      ticks(5);
      rd16(3'd1, v); chk("R2 stopped", v, 16'h0100);

      // R3 timer counting incl carry
      wr(3'd0, 8'h04);
      ticks(5);
      rd16(3'd1, v); chk("R3 tick count", v, 16'h0105);
      set16(3'd1, 16'h00FF);
      ticks(1);
      rd16(3'd1, v); chk("R3 carry", v, 16'h0100);

      // R6 reload on overflow
      set16(3'd3, 16'h1234);
      set16(3'd1, 16'hFFFE);
      ticks(2);
      rd16(3'd1, v); chk("R6 ovf reload", v, 16'h1234);
      rd(3'd0, b); chk("R4 ovf flag", b, 8'h84);
      chk("R9 irq ovf", irq, 1'b1);

      // R4 capture mode wraps, software clear
      wr(3'd0, 8'h05);
      rd(3'd0, b); chk("R4 sw clear", b, 8'h05);
      set16(3'd1, 16'hFFFF);
      ticks(1);
      rd16(3'd1, v); chk("R4 wrap", v, 16'h0000);
      rd(3'd0, b); chk("R4 flag set", b, 8'h85);

      // R5 capture on strobe, R13 latency
      wr(3'd0, 8'h09);
      set16(3'd1, 16'hBEEF);
      @(negedge clk); strb_pin = 1'b0;
      @(negedge clk); @(negedge clk);
      rd16(3'd3, v); chk("R13 not yet", v, 16'h1234);
      @(negedge clk);
      rd16(3'd3, v); chk("R5 capture", v, 16'hBEEF);
      rd(3'd0, b); chk("R8 ext set", b, 8'h49);
      chk("R9 irq ext", irq, 1'b1);
      strb_pin = 1'b1; settle();

      // R8 strobe ignored with strobe_en=0
      wr(3'd0, 8'h01);
      set16(3'd1, 16'h1111);
      @(negedge clk); strb_pin = 1'b0; settle();
      rd16(3'd3, v); chk("R8 no capture", v, 16'hBEEF);
      rd(3'd0, b); chk("R8 no flag", b, 8'h01);
      strb_pin = 1'b1; settle();

      // R6 strobe reload
      wr(3'd0, 8'h08);
      set16(3'd1, 16'h2222);
      @(negedge clk); strb_pin = 1'b0; settle();
      rd16(3'd1, v); chk("R6 strobe reload", v, 16'hBEEF);
      rd(3'd0, b); chk("R8 ext reload", b, 8'h48);
      strb_pin = 1'b1; settle();

      // R7 / R10 transmit bit clock
      wr(3'd0, 8'h00);
      set16(3'd1, 16'hFFFF);
      set16(3'd3, 16'h00F0);
      wr(3'd0, 8'h1D);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      chk("R10 tx pulse", {tx_clk, rx_clk}, 2'b10);
      rd16(3'd1, v); chk("R7 forced reload", v, 16'h00F0);
      rd(3'd0, b); chk("R7 no ovf flag", b, 8'h1D);
      @(negedge clk);
      chk("R10 single cycle", {tx_clk, rx_clk}, 2'b00);
      strb_pin = 1'b0; settle();
      rd16(3'd3, v); chk("R7 strobe ignored cap", v, 16'h00F0);
      rd16(3'd1, v); chk("R7 strobe ignored cnt", v, 16'h00F0);
      rd(3'd0, b); chk("R7 strobe no ext", b, 8'h1D);
      strb_pin = 1'b1; settle();

      // R10 receive bit clock
      wr(3'd0, 8'h24);
      set16(3'd1, 16'hFFFF);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); tick_en = 1'b0;
      chk("R10 rx pulse", {tx_clk, rx_clk}, 2'b01);

      // R3 event counting, tick ignored
      wr(3'd0, 8'h00);
      set16(3'd1, 16'h00FE);
      wr(3'd0, 8'h06);
      tick_en = 1'b1;
      for (int k = 0; k < 3; k++) begin
         evt_pin = 1'b1; settle();
         evt_pin = 1'b0; settle();
      end
      tick_en = 1'b0;
      rd16(3'd1, v); chk("R3 event count", v, 16'h0101);

      // R11 software write beats reload
      wr(3'd0, 8'h00);
      set16(3'd3, 16'h1234);
      set16(3'd1, 16'hFFFF);
      wr(3'd0, 8'h04);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 3'd1; reg_wdata = 8'h55; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd16(3'd1, v); chk("R11 write priority", v, 16'h1255);

      // R12 set beats clear
      set16(3'd1, 16'hFFFF);
      @(negedge clk);
      tick_en = 1'b1; reg_addr = 3'd0; reg_wdata = 8'h04; reg_wr = 1'b1;
      @(negedge clk);
      tick_en = 1'b0; reg_wr = 1'b0;
      rd(3'd0, b); chk("R12 set wins", b, 8'h84);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule